// File: doc/BRIEF.md
# Instruction Word Stream Packer

This block turns a stream of 24-bit instruction words into a stream of 16-bit transfer words for a serial programming link. Words are grouped in pairs. Each pair leaves as three transfer words: the low half of the first word, then a word that carries the two upper bytes side by side, then the low half of the second word. This saves one transfer word out of every four, compared with sending each instruction as two 16-bit words.

If a stream holds an odd number of words, the last one has no partner. It leaves as a shortened tail of two transfer words, and the slot for the missing partner's upper byte is zero. Both sides use valid/ready handshakes with a last flag. The upstream source is held off while a group is being emitted.

Top module: `instr_packer`

## Requirements
- R1: After synchronous reset, `out_valid` is 0 and `in_ready` is 1.
- R2: The first transfer word of every group equals bits [15:0] of the first instruction word of that group.
- R3: For a full pair, the second transfer word has bits [7:0] equal to bits [23:16] of the first instruction word, and bits [15:8] equal to bits [23:16] of the second instruction word.
- R4: For a full pair, the third transfer word equals bits [15:0] of the second instruction word.
- R5: When a stream ends on an unpaired word, the second transfer word has bits [7:0] equal to bits [23:16] of that word and bits [15:8] equal to zero.
- R6: An unpaired final word produces exactly two transfer words. No third word follows, and `out_valid` stays 0 until a new instruction word is accepted.
- R7: `out_last` is 1 on the final transfer word of a stream, for odd and even streams alike, and 0 on every other transfer word.
- R8: While any transfer word of a group is pending (`out_valid` is 1), `in_ready` is 0.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values into the next cycle.
- R10: A synchronous reset discards a held first word of an incomplete pair, so the next pair is formed only from words accepted after the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Block can accept an instruction word |
| in_data | input | 24 | Instruction word |
| in_last | input | 1 | Offered word ends the stream |
| out_valid | output | 1 | Transfer word offered |
| out_ready | input | 1 | Sink accepts the transfer word |
| out_data | output | 16 | Transfer word |
| out_last | output | 1 | Transfer word ends the stream |

## Verification
The hardest situation to reach from the ports is a reset that arrives while the first word of a pair is held and nothing has yet been emitted. From the outside this state looks just like idle. The bench reaches it by offering a single non-final word, asserting reset, and then sending a fresh pair. The output must contain only the new words. The bench also sweeps stream lengths from one to seven words under three output stall patterns. Odd tails and the upper-byte word are therefore seen both under stall and without it.

// File: rtl/ipk_pkg.sv
package ipk_pkg;
    parameter int unsigned INSTR_W = 24;
    parameter int unsigned XFER_W  = 16;
    localparam int unsigned HI_W   = INSTR_W - XFER_W;

    typedef enum logic [2:0] {
        PK_EMPTY  = 3'd0,
        PK_HALF   = 3'd1,
        PK_LOW_A  = 3'd2,
        PK_UPPERS = 3'd3,
        PK_LOW_B  = 3'd4
    } pk_state_e;

    typedef struct packed {
        logic [INSTR_W-1:0] a;
        logic [INSTR_W-1:0] b;
        logic               odd;
        logic               fin;
    } pk_hold_t;

    function automatic logic [XFER_W-1:0] pack_uppers(
        input logic [INSTR_W-1:0] a,
        input logic [INSTR_W-1:0] b,
        input logic               odd
    );
        logic [HI_W-1:0] hi_b;
        hi_b = odd ? '0 : b[INSTR_W-1:XFER_W];
        return {hi_b, a[INSTR_W-1:XFER_W]};
    endfunction
endpackage

// File: rtl/pk_ctrl.sv
module pk_ctrl
    import ipk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    input  logic      in_last,
    input  logic      out_ready,
    input  logic      hold_odd,
    output pk_state_e state,
    output logic      in_ready,
    output logic      out_valid,
    output logic      cap_a,
    output logic      cap_b
);
    pk_state_e nxt;

    assign in_ready  = (state == PK_EMPTY) || (state == PK_HALF);
    assign out_valid = (state == PK_LOW_A) || (state == PK_UPPERS) || (state == PK_LOW_B);
    assign cap_a     = (state == PK_EMPTY) && in_valid;
    assign cap_b     = (state == PK_HALF) && in_valid;

    always_comb begin
        nxt = state;
        unique case (state)
            PK_EMPTY:  if (in_valid) nxt = in_last ? PK_LOW_A : PK_HALF;
            PK_HALF:   if (in_valid) nxt = PK_LOW_A;
            PK_LOW_A:  if (out_ready) nxt = PK_UPPERS;
            PK_UPPERS: if (out_ready) nxt = hold_odd ? PK_EMPTY : PK_LOW_B;
            PK_LOW_B:  if (out_ready) nxt = PK_EMPTY;
            default:   nxt = PK_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PK_EMPTY;
        else     state <= nxt;
    end
endmodule

// File: rtl/pk_hold.sv
module pk_hold
    import ipk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cap_a,
    input  logic               cap_b,
    input  logic [INSTR_W-1:0] in_data,
    input  logic               in_last,
    output pk_hold_t           hold
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= '0;
        end else if (cap_a) begin
            hold.a   <= in_data;
            hold.b   <= '0;
            hold.odd <= in_last;
            hold.fin <= in_last;
        end else if (cap_b) begin
            hold.b   <= in_data;
            hold.odd <= 1'b0;
            hold.fin <= in_last;
        end
    end
endmodule

// File: rtl/pk_select.sv
module pk_select
    import ipk_pkg::*;
(
    input  pk_state_e          state,
    input  pk_hold_t           hold,
    output logic [XFER_W-1:0]  out_data,
    output logic               out_last
);
    always_comb begin
        out_data = '0;
        out_last = 1'b0;
        case (state)
            PK_LOW_A: begin
                out_data = hold.a[XFER_W-1:0];
            end
            PK_UPPERS: begin
                out_data = pack_uppers(hold.a, hold.b, hold.odd);
                out_last = hold.odd;
            end
            PK_LOW_B: begin
                out_data = hold.b[XFER_W-1:0];
                out_last = hold.fin;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/instr_packer.sv
module instr_packer
    import ipk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [INSTR_W-1:0] in_data,
    input  logic               in_last,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [XFER_W-1:0]  out_data,
    output logic               out_last
);
    pk_state_e state;
    pk_hold_t  hold;
    logic      cap_a;
    logic      cap_b;

    pk_ctrl u_ctrl (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
        .out_ready(out_ready), .hold_odd(hold.odd), .state(state),
        .in_ready(in_ready), .out_valid(out_valid), .cap_a(cap_a), .cap_b(cap_b)
    );

    pk_hold u_hold (
        .clk(clk), .rst(rst), .cap_a(cap_a), .cap_b(cap_b),
        .in_data(in_data), .in_last(in_last), .hold(hold)
    );

    pk_select u_sel (
        .state(state), .hold(hold), .out_data(out_data), .out_last(out_last)
    );
endmodule

// File: rtl/pk_checker.sv
module pk_checker
    import ipk_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [XFER_W-1:0] out_data,
    input logic              out_last
);
    // R1: first cycle after reset is idle and open for input
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && in_ready));

    // R8: input held off while a group is pending
    a_r8_no_accept_while_emit: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    // R9: stalled output holds
    a_r9_stall_holds: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R6 / R7: after the stream's last word goes, nothing more is offered
    a_r6_quiet_after_last: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> (!out_valid && in_ready));
endmodule

bind instr_packer pk_checker u_chk (
    .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
);

// File: tb/instr_packer_tb.sv
module instr_packer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [23:0] in_data = '0;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] out_data;
    logic        out_last;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int bp_mode = 0;
    logic [7:0] lfsr = 8'h5A;

    logic [15:0] q_data[$];
    bit          q_last[$];
    int          q_req[$];

    logic        prev_stall = 1'b0;
    logic [15:0] prev_data  = '0;
    logic        prev_last  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    instr_packer u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // monitor: drives out_ready, checks every transfer word
    always @(negedge clk) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        case (bp_mode)
            0: out_ready = 1'b1;
            1: out_ready = cyc[0];
            default: out_ready = lfsr[0];
        endcase
        if (!rst) begin
            if (prev_stall) begin
                // R9
                chk(out_valid && out_data == prev_data && out_last == prev_last,
                    "R9", {15'd0, out_valid, out_data}, {15'd1, 1'b1, prev_data});
            end
            if (out_valid) begin
                // R8
                chk(!in_ready, "R8", {31'd0, in_ready}, 32'd0);
            end
            if (out_valid && out_ready) begin
                if (q_data.size() == 0) begin
                    chk(1'b0, "R6", {16'd0, out_data}, 32'd0);
                end else begin
                    automatic logic [15:0] ed = q_data.pop_front();
                    automatic bit          el = q_last.pop_front();
                    automatic int          er = q_req.pop_front();
                    chk(out_data == ed, $sformatf("R%0d", er), {16'd0, out_data}, {16'd0, ed});
                    // R7
                    chk(out_last == el, "R7", {31'd0, out_last}, {31'd0, el});
                end
            end
        end
        prev_stall = !rst && out_valid && !out_ready;
        prev_data  = out_data;
        prev_last  = out_last;
    end

    task automatic send(input logic [23:0] d, input bit last);
        bit r;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        in_last  = last;
        forever begin
            #1 r = in_ready;
            @(posedge clk);
            if (r) break;
            @(negedge clk);
        end
    endtask

    task automatic expect_stream(input logic [23:0] w[], input int n);
        for (int k = 0; k < n; k += 2) begin
            q_data.push_back(w[k][15:0]); q_last.push_back(1'b0); q_req.push_back(2);   // R2
            if (k + 1 < n) begin
                q_data.push_back({w[k+1][23:16], w[k][23:16]});                          // R3
                q_last.push_back(1'b0); q_req.push_back(3);
                q_data.push_back(w[k+1][15:0]);                                          // R4
                q_last.push_back(k + 2 == n); q_req.push_back(4);
            end else begin
                q_data.push_back({8'h00, w[k][23:16]});                                  // R5
                q_last.push_back(1'b1); q_req.push_back(5);
            end
        end
    endtask

    task automatic drain_and_check_idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        while (q_data.size() != 0) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        // R6: nothing more after the tail / last word
        #1 chk(!out_valid && in_ready, "R6", {31'd0, out_valid}, 32'd0);
    endtask

    initial begin
        logic [23:0] w[];
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        #1 chk(!out_valid && in_ready, "R1", {30'd0, out_valid, in_ready}, 32'd1);

        for (int m = 0; m < 3; m++) begin
            bp_mode = m;
            for (int n = 1; n <= 7; n++) begin
                w = new[n];
                for (int k = 0; k < n; k++)
                    w[k] = 24'(((m * 7 + n) * 24'h01F3A5) ^ (k * 24'h3C5A69) ^ 24'h81_0000);
                expect_stream(w, n);
                for (int k = 0; k < n; k++) send(w[k], k == n - 1);
                drain_and_check_idle();
            end
        end

        // R10: reset with a held half-pair, then a fresh pair
        bp_mode = 0;
        send(24'hABCDEF, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1 chk(!out_valid && in_ready, "R10", {30'd0, out_valid, in_ready}, 32'd1);
        w = new[2];
        w[0] = 24'h123456;
        w[1] = 24'h9A7B3C;
        expect_stream(w, 2);
        send(w[0], 1'b0);
        send(w[1], 1'b1);
        drain_and_check_idle();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule